// File: doc/BRIEF.md
# Subtractive GCD Processor

This block finds the greatest common divisor of two nonzero unsigned operands. It works by subtracting the smaller register from the larger one until the two are equal. A controller and a datapath make up the design. The controller is a 4-bit state machine that follows a structured program step by step. The datapath holds two working registers, a result register, a load multiplexer in front of each working register, one subtractor in each direction, an inequality comparator and a less-than comparator.

A user places the operands on `opa` and `opb` and raises `start`. The controller samples `start` only while it waits in its idle test. Once a run begins, `opa` is captured on the next edge and `opb` on the edge after that. The result register changes only at the single load step at the end of a run. Between runs, `result` keeps showing the last answer. If `start` is still high when a run ends, a new run begins on its own.

Top module: `gcd_sub_fsmd`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to 0 on the next rising edge and returns the controller to its initial state (code 0000).
- R2: While `start` is low, the controller alternates between its wait test and its wait join, and `result` does not change.
- R3: For nonzero operands, `result` ends up equal to gcd(`opa`, `opb`).
- R4: Call the edge that samples `start` high edge s. `result` takes the new value exactly at edge s+4+5k, where k is the number of subtraction steps the run needs. Before that edge it keeps its old value.
- R5: During a run, `result` holds the previous answer until the load edge.
- R6: `opa` is captured at edge s+1 and `opb` at edge s+2. Changes to either operand after edge s+2 have no effect on the run.
- R7: Equal operands need no subtraction (k=0), and the result is the operand value.
- R8: If `start` stays high, the edge three cycles after a load edge L samples it again. The next run's result appears at edge L+3+4+5k'.
- R9: After reset the controller first reaches its wait test, and it samples `start` only from that state. When `start` rises while the controller sits in the wait join, sampling is delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a run |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| result | output | W | Last computed GCD |

## Verification
After a reset, the bench counts rising edges and works out from R9 which edge s samples `start`. It also counts the subtractions k for each operand pair, which gives the load edge s+4+5k. At the negative edge before that load edge, the bench checks that `result` still shows the old value. At the negative edge just after it, the bench checks for the new GCD. Operands are changed right after edge s+2 to show that they are no longer read. In back-to-back runs, the following load edge is predicted as L+3+4+5k'.

// File: rtl/gcd_sub_fsmd.sv
module gcd_sub_fsmd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result
);

  localparam logic [3:0] S_INIT  = 4'b0000;
  localparam logic [3:0] S_WAIT  = 4'b0001;
  localparam logic [3:0] S_WJOIN = 4'b0010;
  localparam logic [3:0] S_LDA   = 4'b0011;
  localparam logic [3:0] S_LDB   = 4'b0100;
  localparam logic [3:0] S_NEQ   = 4'b0101;
  localparam logic [3:0] S_LT    = 4'b0110;
  localparam logic [3:0] S_SUBB  = 4'b0111;
  localparam logic [3:0] S_SUBA  = 4'b1000;
  localparam logic [3:0] S_IFJ   = 4'b1001;
  localparam logic [3:0] S_LPJ   = 4'b1010;
  localparam logic [3:0] S_LDD   = 4'b1011;
  localparam logic [3:0] S_OUTJ  = 4'b1100;

  logic [3:0]   st, st_nxt;
  logic [W-1:0] a_q, b_q, d_q;
  logic         a_pick, b_pick, a_ld, b_ld, d_ld;
  logic         ne_flag, lt_flag;

  assign ne_flag = (a_q != b_q);
  assign lt_flag = (a_q < b_q);
  assign result  = d_q;

  always_comb begin
    st_nxt = S_INIT;
    a_pick = 1'b0;
    b_pick = 1'b0;
    a_ld   = 1'b0;
    b_ld   = 1'b0;
    d_ld   = 1'b0;
    case (st)
      S_INIT:  st_nxt = S_WAIT;
      S_WAIT:  st_nxt = start ? S_LDA : S_WJOIN;
      S_WJOIN: st_nxt = S_WAIT;
      S_LDA:   begin st_nxt = S_LDB; a_ld = 1'b1; end
      S_LDB:   begin st_nxt = S_NEQ; b_ld = 1'b1; end
      S_NEQ:   st_nxt = ne_flag ? S_LT : S_LDD;
      S_LT:    st_nxt = lt_flag ? S_SUBB : S_SUBA;
      S_SUBB:  begin st_nxt = S_IFJ; b_pick = 1'b1; b_ld = 1'b1; end
      S_SUBA:  begin st_nxt = S_IFJ; a_pick = 1'b1; a_ld = 1'b1; end
      S_IFJ:   st_nxt = S_LPJ;
      S_LPJ:   st_nxt = S_NEQ;
      S_LDD:   begin st_nxt = S_OUTJ; d_ld = 1'b1; end
      S_OUTJ:  st_nxt = S_INIT;
      default: st_nxt = S_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_INIT;
      a_q <= '0;
      b_q <= '0;
      d_q <= '0;
    end else begin
      st <= st_nxt;
      if (a_ld) a_q <= a_pick ? (a_q - b_q) : opa;
      if (b_ld) b_q <= b_pick ? (b_q - a_q) : opb;
      if (d_ld) d_q <= a_q;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (result == '0 && st == S_INIT));
  a_r2_idle_loops: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !start) |=> (st == S_WJOIN && $stable(result)));
  a_r3_equal_at_load: assert property (@(posedge clk) disable iff (rst)
    (st == S_LDD) |-> (a_q == b_q));
  a_r4_sub_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (st == S_SUBB) |-> (a_q < b_q));
  a_r5_result_only_on_load: assert property (@(posedge clk) disable iff (rst)
    (st != S_LDD) |=> $stable(result));
  a_r6_capture_opa: assert property (@(posedge clk) disable iff (rst)
    (st == S_LDA) |=> (a_q == $past(opa)));
  a_r9_sample_only_in_wait: assert property (@(posedge clk) disable iff (rst)
    (st != S_WAIT && st != S_OUTJ) |=> (st != S_LDA));

endmodule

// File: tb/sim_gcd_sub_fsmd.sv
module sim_gcd_sub_fsmd;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] result;
  int edges = 0;
  int checks = 0;
  int fails = 0;

  gcd_sub_fsmd #(.W(W)) u0 (.clk(clk), .rst(rst), .start(start), .opa(opa), .opb(opb), .result(result));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= 0;
    else edges <= edges + 1;
  end

  function automatic int gcd_ref(int a, int b);
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
    end
    return a;
  endfunction

  function automatic int subs_ref(int a, int b);
    int n = 0;
    while (a != b) begin
      if (a < b) b = b - a; else a = a - b;
      n++;
    end
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    @(negedge clk);
    chk("R1", int'(result), 0);
    rst = 1'b0;
  endtask

  task automatic run(int a, int b, int m, int scramble, output int lastl);
    int s, l;
    do_reset();
    opa = W'(a); opb = W'(b);
    wait_edge(m - 1);
    chk("R2", int'(result), 0);
    start = 1'b1;
    s = (m % 2 == 0) ? m : m + 1;
    l = s + 4 + 5 * subs_ref(a, b);
    wait_edge(s + 2);
    if (scramble != 0) begin
      opa = W'(($urandom % 255) + 1);
      opb = W'(($urandom % 255) + 1);
    end
    wait_edge(l - 1);
    chk("R4 R5 before load", int'(result), 0);
    wait_edge(l);
    if (a == b) chk("R7", int'(result), a);
    chk("R3 R4 R6", int'(result), gcd_ref(a, b));
    lastl = l;
  endtask

  initial begin
    int l, l2, g1, a2, b2;
    void'($urandom(32'd1234));
    run(42, 8, 2, 1, l);
    start = 1'b0;
    run(5, 5, 2, 0, l);
    start = 1'b0;
    run(13, 7, 3, 1, l);
    start = 1'b0;
    run(1, 255, 4, 1, l);
    start = 1'b0;
    run(255, 1, 7, 0, l);
    start = 1'b0;
    run(128, 96, 9, 1, l);
    g1 = gcd_ref(128, 96);
    a2 = 90; b2 = 35;
    opa = W'(a2); opb = W'(b2);
    l2 = l + 3 + 4 + 5 * subs_ref(a2, b2);
    wait_edge(l2 - 1);
    chk("R5 R8 old held", int'(result), g1);
    wait_edge(l2);
    chk("R8 next run", int'(result), gcd_ref(a2, b2));
    start = 1'b0;
    wait_edge(l2 + 20);
    chk("R2 idle hold", int'(result), gcd_ref(a2, b2));
    for (int i = 0; i < 30; i++) begin
      int ra = ($urandom % 255) + 1;
      int rb = ($urandom % 255) + 1;
      int rm = ($urandom % 8) + 2;
      run(ra, rb, rm, 1, l);
      start = 1'b0;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule